// File: doc/BRIEF.md
# Transaction Tag Free-List Allocator

This block hands out and takes back transaction identifiers drawn from a pool of 32 five-bit tags. A requester pulses a take strobe to claim the tag shown on the issue output. When that transaction retires, the completing side pulses a put strobe with the tag value, and the tag goes back into the pool. Returned tags join the tail of a circular free list, so they are reissued out of numeric order, in the order in which they came back.

The block drives a flag that tells upstream logic to stop allocating while every tag is in use. For a status register it reports the number of outstanding transactions (0 to 32) and two flags: all tags outstanding, and none outstanding. A strobe that cannot be honoured is dropped and sets a sticky error bit, which only reset clears.

Top module: `tag_pool_alloc`

## Requirements
- R1: After reset, the pending count is 0, the empty status is 1, the full status and the no-free-tag flag are 0, the error bit is 0, and the issue output shows tag 0.
- R2: After reset, successive takes are given tags 0, 1, 2 and so on up to 31, in that order.
- R3: A take alone raises the pending count by one in the next cycle. A put alone lowers it by one.
- R4: The no-free-tag flag and the full status are 1 exactly when the pending count is 32. The empty status is 1 exactly when the pending count is 0.
- R5: A take while the no-free-tag flag is 1 is ignored: no tag leaves the pool and the count does not change. It sets the error bit.
- R6: A put while the pending count is 0 is ignored: the pool and the count are unchanged. It sets the error bit.
- R7: Returned tags are reissued first-in first-out, after the tags that were already free when they were returned.
- R8: A legal take and a legal put in the same cycle are both honoured. The count stays the same, and the issued tag is the one at the free-list head before the put.
- R9: Once set, the error bit stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low; refills the pool |
| take_i | input | 1 | Claim the tag currently on issue_tag_o |
| put_i | input | 1 | Return the tag on put_tag_i |
| put_tag_i | input | 5 | Tag being retired |
| issue_tag_o | output | 5 | Tag at the free-list head |
| none_free_o | output | 1 | No tag available; stop allocating |
| stat_full_o | output | 1 | Status: every tag outstanding |
| stat_empty_o | output | 1 | Status: no tag outstanding |
| stat_pending_o | output | 6 | Status: outstanding transaction count |
| err_o | output | 1 | Sticky flag for an illegal take or put |

## Verification
On every cycle, the assertions check the count step for a take alone, a put alone and both together, the upper bound of the count, that a take while exhausted is blocked, and that the error bit is sticky. Only the bench scenarios can show the tag values themselves: the initial order 0 to 31, the first-in first-out reuse of returned tags, and the head tag seen during a simultaneous take and put. To show these, the bench follows the free list with its own queue model through directed sequences and a long random run.

// File: rtl/tag_pool_alloc.sv
module tag_pool_alloc #(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             put_i,
  input  logic [TAG_W-1:0] put_tag_i,
  output logic [TAG_W-1:0] issue_tag_o,
  output logic             none_free_o,
  output logic             stat_full_o,
  output logic             stat_empty_o,
  output logic [TAG_W:0]   stat_pending_o,
  output logic             err_o
);
  localparam int NUM_TAGS = 1 << TAG_W;
  localparam int CNT_W    = TAG_W + 1;

  logic [TAG_W-1:0] slot [NUM_TAGS];
  logic [TAG_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] pend;
  logic             take_ok, put_ok;

  assign none_free_o    = (pend == CNT_W'(NUM_TAGS));
  assign take_ok        = take_i && !none_free_o;
  assign put_ok         = put_i && (pend != '0);
  assign issue_tag_o    = slot[rd_ptr];
  assign stat_full_o    = none_free_o;
  assign stat_empty_o   = (pend == '0);
  assign stat_pending_o = pend;

  // circular free list; pointers wrap because the depth is a power of two
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TAGS; i++) slot[i] <= TAG_W'(i);
      rd_ptr <= '0;
      wr_ptr <= '0;
      pend   <= '0;
      err_o  <= 1'b0;
    end else begin
      if (take_ok) rd_ptr <= rd_ptr + 1'b1;
      if (put_ok) begin
        slot[wr_ptr] <= put_tag_i;
        wr_ptr       <= wr_ptr + 1'b1;
      end
      case ({take_ok, put_ok})
        2'b10:   pend <= pend + 1'b1;
        2'b01:   pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
      if ((take_i && !take_ok) || (put_i && !put_ok)) err_o <= 1'b1;
    end
  end

  assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && !put_i && !none_free_o |=> stat_pending_o == CNT_W'($past(stat_pending_o) + 1'b1));

  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    put_i && !take_i && !stat_empty_o |=> stat_pending_o == CNT_W'($past(stat_pending_o) - 1'b1));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && put_i && !stat_empty_o && !none_free_o |=> $stable(stat_pending_o));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pending_o <= CNT_W'(NUM_TAGS));

  assert_take_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_i && !put_i && none_free_o |=> err_o && $stable(stat_pending_o));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
endmodule

// File: tb/tag_pool_alloc_bench.sv
module tag_pool_alloc_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       take_i = 0, put_i = 0;
  logic [4:0] put_tag_i = '0;
  logic [4:0] issue_tag_o;
  logic       none_free_o, stat_full_o, stat_empty_o, err_o;
  logic [5:0] stat_pending_o;

  int errors = 0, checks = 0;
  logic [4:0] free_q[$];
  logic [4:0] out_q[$];
  int  m_pend;
  bit  m_err;

  always #4 clk = ~clk;

  tag_pool_alloc u_tag_pool_alloc (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .put_i(put_i), .put_tag_i(put_tag_i),
    .issue_tag_o(issue_tag_o), .none_free_o(none_free_o), .stat_full_o(stat_full_o),
    .stat_empty_o(stat_empty_o), .stat_pending_o(stat_pending_o), .err_o(err_o));

  function automatic bit exp_full(int p);  return p == 32; endfunction
  function automatic bit exp_empty(int p); return p == 0;  endfunction

  task automatic check(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic compare(string rq);
    check(stat_pending_o == 6'(m_pend), rq, "pending", stat_pending_o, m_pend);
    check(none_free_o == exp_full(m_pend), "R4", "none_free", none_free_o, exp_full(m_pend));
    check(stat_full_o == exp_full(m_pend), "R4", "full", stat_full_o, exp_full(m_pend));
    check(stat_empty_o == exp_empty(m_pend), "R4", "empty", stat_empty_o, exp_empty(m_pend));
    check(err_o == m_err, rq, "err", err_o, m_err);
    if (free_q.size() > 0)
      check(issue_tag_o == free_q[0], rq, "issue_tag", issue_tag_o, free_q[0]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; take_i = 0; put_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    free_q.delete(); out_q.delete();
    for (int i = 0; i < 32; i++) free_q.push_back(5'(i));
    m_pend = 0; m_err = 0;
  endtask

  // called at a negedge; applies one cycle of stimulus and checks the result
  task automatic cyc(bit tk, bit pt, logic [4:0] tg, string rq);
    bit lt, lp;
    take_i = tk; put_i = pt; put_tag_i = tg;
    lt = tk && (m_pend < 32);
    lp = pt && (m_pend > 0);
    if (lt) begin
      #1 check(issue_tag_o == free_q[0], rq, "issue_before_take", issue_tag_o, free_q[0]);
      out_q.push_back(free_q.pop_front());
    end
    if (lp) begin
      free_q.push_back(tg);
      foreach (out_q[k]) if (out_q[k] == tg) begin out_q.delete(k); break; end
    end
    if (lt && !lp) m_pend++;
    if (lp && !lt) m_pend--;
    if ((tk && !lt) || (pt && !lp)) m_err = 1;
    @(negedge clk);
    take_i = 0; put_i = 0;
    compare(rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    compare("R1");
    check(issue_tag_o == 5'd0, "R1", "first_tag", issue_tag_o, 0);

    for (int i = 0; i < 32; i++) begin
      check(issue_tag_o == 5'(i), "R2", "ordered_issue", issue_tag_o, i);
      cyc(1, 0, 0, "R3");
    end
    compare("R4");
    cyc(1, 0, 0, "R5");
    check(err_o == 1'b1, "R5", "err_after_blocked_take", err_o, 1);
    cyc(0, 1, 5'd7, "R3");
    cyc(0, 1, 5'd3, "R3");
    cyc(1, 0, 0, "R7");
    cyc(0, 0, 0, "R9");
    check(err_o == 1'b1, "R9", "err_held", err_o, 1);
    check(issue_tag_o == 5'd3, "R7", "second_returned", issue_tag_o, 3);

    do_reset();
    cyc(0, 1, 5'd9, "R6");
    check(stat_pending_o == 6'd0, "R6", "pending_after_bad_put", stat_pending_o, 0);
    check(issue_tag_o == 5'd0, "R6", "head_after_bad_put", issue_tag_o, 0);

    do_reset();
    cyc(1, 0, 0, "R8");
    cyc(1, 1, 5'd0, "R8");
    check(issue_tag_o == 5'd2, "R8", "head_after_both", issue_tag_o, 2);

    for (int n = 0; n < 4000; n++) begin
      bit tk, pt;
      logic [4:0] tg;
      int bias;
      bias = (n / 500) % 2 ? 70 : 30;
      tk = ($urandom % 100) < bias;
      pt = ($urandom % 100) < (100 - bias);
      tg = 0;
      if (out_q.size() == 0) pt = 0;
      else tg = out_q[$urandom % out_q.size()];
      if (m_pend == 32 && ($urandom % 4) != 0) tk = 0;
      cyc(tk, pt, tg, (tk && pt) ? "R8" : "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule